// File: doc/BRIEF.md
# MSR Permission Bitmap Checker

This block decides whether a guest access to a model-specific register must leave the guest. A request carries a 32-bit register index, a read/write select and the base address of a permission map in memory. Three separate 8192-entry index windows are folded into one packed map. Each register owns two adjacent bits in that map: the lower bit governs reads and the upper bit governs writes.

When guest mode is active and the general register-access intercept is enabled, the block works out which map byte and which bit to test. It then issues one byte read on a plain request/response memory port and reports exit when the selected bit is set. An index that falls in none of the windows produces an exit at once, with no memory access. With guest mode off or the intercept disabled, the answer is no-exit, also with no memory access.

Each answer comes with a one-cycle done pulse and a qualifier that tells reads from writes. A start strobe that arrives while a decision is in progress is dropped.

Top module: `msr_perm_chk`

## Requirements
- R1: After reset, done_o, mem_req_o and exit_o are all low.
- R2: If guest_i or icpt_en_i is low when a start is accepted, done_o rises in the next cycle with exit_o=0, and no memory request is made.
- R3: If the index lies outside all three windows (0x0000_0000..0x0000_1FFF, 0xC000_0000..0xC000_1FFF, 0xC001_0000..0xC001_1FFF), done_o rises in the next cycle with exit_o=1, and no memory request is made.
- R4: For an index in 0x0000_0000..0x0000_1FFF, the bit index is index*2.
- R5: For an index in 0xC000_0000..0xC000_1FFF, the bit index is (8192 + index - 0xC000_0000)*2.
- R6: For an index in 0xC001_0000..0xC001_1FFF, the bit index is (16384 + index - 0xC001_0000)*2.
- R7: The byte read is at map_base_i + bitindex/8. Within that byte the bit tested is bitindex mod 8 for a read (wr_i=0) and bitindex mod 8 + 1 for a write (wr_i=1).
- R8: A lookup raises mem_req_o for exactly one cycle, with a valid address, and holds the address until the response. exit_o equals the tested bit of mem_rsp_data_i, and done_o is a one-cycle pulse in the cycle after mem_rsp_valid_i.
- R9: A start strobe that arrives while a decision is in progress is ignored. The result belongs to the accepted request, and only one memory request is made.
- R10: exit_info_o is 0 for a read and 1 for a write. It is valid while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; accepted only when the block is idle |
| msr_idx_i | input | 32 | Register index of the access |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| map_base_i | input | ADDR_W | Byte address of the permission map |
| guest_i | input | 1 | Guest mode active |
| icpt_en_i | input | 1 | General register-access intercept enabled |
| mem_req_o | output | 1 | One-cycle byte read request |
| mem_addr_o | output | ADDR_W | Byte address of the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 8 | Read data byte |
| done_o | output | 1 | Decision ready, one-cycle pulse |
| exit_o | output | 1 | 1 = access must exit |
| exit_info_o | output | 1 | 0 = read, 1 = write |

## Verification
Random indices are drawn both inside each of the three windows and across the whole 32-bit range, with random map bases, read/write selects and enable combinations. Each result is compared with a map byte that the bench derives from its address. The in-window draws test the packing offset of each window and the choice between the read bit and the write bit. The out-of-range draws and the disabled draws test the two shortcuts that make no memory access. Directed cases hit the first and last index of each window and the index just past it, and they repeat start strobes while the block is busy to show that late strobes are dropped.

// File: rtl/msrp_pkg.sv
package msrp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } msrp_state_e;

  localparam int unsigned NUM_WIN = 3;

  // Base index of window w. The order sets the packing slot of each window.
  function automatic logic [31:0] win_base(input int unsigned w);
    case (w)
      0:       win_base = 32'h0000_0000;
      1:       win_base = 32'hC000_0000;
      default: win_base = 32'hC001_0000;
    endcase
  endfunction

  // Pick the tested bit from the pair: low bit for read, high bit for write.
  function automatic logic [2:0] pick_bit(input logic [2:0] pair_lsb, input logic wr);
    pick_bit = pair_lsb | {2'b00, wr};
  endfunction

endpackage

// File: rtl/msrp_decode.sv
module msrp_decode
  import msrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 13
) (
  input  logic [31:0]       idx_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [2:0]        bit_pos_o
);
  localparam int unsigned PAIR_W = WIN_W + 2;
  localparam int unsigned BIT_W  = PAIR_W + 1;

  logic [NUM_WIN-1:0] win_hit;
  logic [PAIR_W-1:0]  win_pair [NUM_WIN];
  logic [PAIR_W-1:0]  pair_off;
  logic [BIT_W-1:0]   bit_idx;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [31:0] WB = win_base(w);
    assign win_hit[w]  = (idx_i[31:WIN_W] == WB[31:WIN_W]);
    assign win_pair[w] = {2'(w), idx_i[WIN_W-1:0]};
  end

  always_comb begin
    pair_off = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_hit[w]) pair_off = pair_off | win_pair[w];
    end
  end

  assign hit_o       = |win_hit;
  assign bit_idx     = {pair_off, 1'b0};
  assign byte_addr_o = base_i + ADDR_W'(bit_idx[BIT_W-1:3]);
  assign bit_pos_o   = pick_bit(bit_idx[2:0], wr_i);

  // Windows do not overlap, so at most one hit.
  always_comb begin
    a_r3_one_window: assert ($onehot0(win_hit));
  end
endmodule

// File: rtl/msrp_ctrl.sv
module msrp_ctrl
  import msrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [2:0]        bit_pos_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [7:0]        mem_rsp_data_i,
  output logic              done_o,
  output logic              exit_o,
  output logic              exit_info_o
);
  msrp_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              wr_q;
  logic              exit_q;

  // Named events for the assertions.
  logic accept_w, busy_w, rsp_take_w;
  assign accept_w   = start_i && (state_q == ST_IDLE);
  assign busy_w     = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign rsp_take_w = (state_q == ST_WAIT) && mem_rsp_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      wr_q    <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_w) begin
          wr_q <= wr_i;
          if (!en_i) begin
            exit_q  <= 1'b0;
            state_q <= ST_DONE;
          end else if (!hit_i) begin
            exit_q  <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            addr_q  <= byte_addr_i;
            bit_q   <= bit_pos_i;
            state_q <= ST_REQ;
          end
        end
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take_w) begin
          exit_q  <= mem_rsp_data_i[bit_q];
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_REQ);
  assign mem_addr_o  = addr_q;
  assign done_o      = (state_q == ST_DONE);
  assign exit_o      = exit_q;
  assign exit_info_o = wr_q;

  a_r2_disabled_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !en_i |=> done_o && !exit_o && !mem_req_o);
  a_r3_outside_exit: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && en_i && !hit_i |=> done_o && exit_o && !mem_req_o);
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> $stable(mem_addr_o));
  a_r8_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take_w |=> done_o && (exit_o == $past(mem_rsp_data_i[bit_q])));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && start_i |=> $stable(exit_info_o) && $stable(mem_addr_o));
endmodule

// File: rtl/msr_perm_chk.sv
module msr_perm_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       msr_idx_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] map_base_i,
  input  logic              guest_i,
  input  logic              icpt_en_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [7:0]        mem_rsp_data_i,
  output logic              done_o,
  output logic              exit_o,
  output logic              exit_info_o
);
  logic              hit_w;
  logic [ADDR_W-1:0] byte_addr_w;
  logic [2:0]        bit_pos_w;
  logic              en_w;

  assign en_w = guest_i && icpt_en_i;

  msrp_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dec (
    .idx_i       (msr_idx_i),
    .wr_i        (wr_i),
    .base_i      (map_base_i),
    .hit_o       (hit_w),
    .byte_addr_o (byte_addr_w),
    .bit_pos_o   (bit_pos_w)
  );

  msrp_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .wr_i            (wr_i),
    .en_i            (en_w),
    .hit_i           (hit_w),
    .byte_addr_i     (byte_addr_w),
    .bit_pos_i       (bit_pos_w),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .done_o          (done_o),
    .exit_o          (exit_o),
    .exit_info_o     (exit_info_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !done_o && !mem_req_o && !exit_o);
endmodule

// File: tb/sim_msr_perm_chk.sv
`timescale 1ns/1ps
module sim_msr_perm_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] msr_idx_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] map_base_i = '0;
  logic        guest_i = 1'b0;
  logic        icpt_en_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [7:0]  mem_rsp_data_i = '0;
  logic        done_o, exit_o, exit_info_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  msr_perm_chk u0 (.*);

  function automatic logic [7:0] map_byte(input logic [31:0] a);
    map_byte = a[7:0] ^ a[15:8] ^ (a[23:16] * 8'd3) ^ 8'h5A;
  endfunction

  // Returns -1 when the index is outside every window.
  function automatic longint bit_index(input logic [31:0] m);
    if (m <= 32'h0000_1FFF) return longint'(m) * 2;
    if (m >= 32'hC000_0000 && m <= 32'hC000_1FFF)
      return (8192 + longint'(m) - 64'hC000_0000) * 2;
    if (m >= 32'hC001_0000 && m <= 32'hC001_1FFF)
      return (16384 + longint'(m) - 64'hC001_0000) * 2;
    return -1;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] m, input logic w, input logic [31:0] b,
                     input logic g, input logic e, input logic poke);
    logic        got = 0, req_d = 0;
    int          nreq = 0;
    logic [31:0] cap = '0;
    longint      bi;
    logic [31:0] ea;
    logic        eexit;
    @(negedge clk);
    msr_idx_i = m; wr_i = w; map_base_i = b; guest_i = g; icpt_en_i = e;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      msr_idx_i = ~m; wr_i = ~w; map_base_i = b + 32'h40; guest_i = 1; icpt_en_i = 1;
    end
    for (int c = 0; c < 40 && !got; c++) begin
      if (c > 0) @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (done_o) begin
        got = 1;
        start_i = 1'b0;
      end else begin
        start_i = poke;
        if (req_d) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = map_byte(cap);
          req_d = 0;
        end
        if (mem_req_o) begin
          req_d = 1; nreq++; cap = mem_addr_o;
        end
      end
    end
    if (!got) begin
      n_chk++; n_fail++;
      $display("FAIL R8 actual=no-done expected=done idx=%0h", m);
      return;
    end
    bi = bit_index(m);
    check("R10 exit info", 64'(exit_info_o), 64'(w));
    if (!(g && e)) begin
      check("R2 disabled exit", 64'(exit_o), 0);
      check("R2 disabled no read", 64'(nreq), 0);
    end else if (bi < 0) begin
      check("R3 outside exit", 64'(exit_o), 1);
      check("R3 outside no read", 64'(nreq), 0);
    end else begin
      ea = b + 32'(bi / 8);
      eexit = map_byte(ea)[32'(bi % 8) + 32'(w)];
      check(poke ? "R9 one request" : "R8 one request", 64'(nreq), 1);
      check(m < 32'h2000 ? "R4/R7 addr" : (m < 32'hC001_0000 ? "R5/R7 addr" : "R6/R7 addr"),
            64'(cap), 64'(ea));
      check(poke ? "R9 exit" : "R7 R8 exit", 64'(exit_o), 64'(eexit));
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    #1;
    check("R1 done", 64'(done_o), 0);
    check("R1 req", 64'(mem_req_o), 0);
    check("R1 exit", 64'(exit_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Directed: window edges
    run(32'h0000_0000, 0, 32'h1000, 1, 1, 0);
    run(32'h0000_1FFF, 1, 32'h1000, 1, 1, 0);
    run(32'h0000_2000, 0, 32'h1000, 1, 1, 0);
    run(32'hC000_0000, 1, 32'h2000, 1, 1, 0);
    run(32'hC000_1FFF, 0, 32'h2000, 1, 1, 0);
    run(32'hC000_2000, 1, 32'h2000, 1, 1, 0);
    run(32'hC001_0000, 0, 32'h3000, 1, 1, 0);
    run(32'hC001_1FFF, 1, 32'h3000, 1, 1, 0);
    run(32'hC001_2000, 0, 32'h3000, 1, 1, 0);
    run(32'hFFFF_FFFF, 1, 32'h3000, 1, 1, 0);
    // Directed: disabled combinations
    run(32'h0000_0010, 0, 32'h1000, 0, 1, 0);
    run(32'hC000_0010, 1, 32'h1000, 1, 0, 0);
    run(32'h1234_5678, 1, 32'h1000, 0, 0, 0);
    // Directed: strobes while busy
    run(32'h0000_0123, 1, 32'h8000, 1, 1, 1);
    run(32'hC001_0456, 0, 32'h8000, 1, 1, 1);
    // Random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] m;
      int k = $urandom % 4;
      case (k)
        0: m = 32'h0000_0000 + ($urandom % 8192);
        1: m = 32'hC000_0000 + ($urandom % 8192);
        2: m = 32'hC001_0000 + ($urandom % 8192);
        default: m = $urandom;
      endcase
      run(m, 1'($urandom), $urandom, ($urandom % 8) != 0, ($urandom % 8) != 0,
          ($urandom % 6) == 0);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule